// File: doc/BRIEF.md
# Reset and power-mode state controller

This block combines three active-low reset sources into a system reset and runs the power-mode machine that decides which clocks may toggle. The sources are power-on, power-fail and user reset. There are two reset outputs. One resets the general logic. The other resets a retained domain that holds the DRAM refresh and configuration registers and the real-time clock. Only power-on clears the retained domain. The two warm sources (power-fail and user) first ask the memory controller to put external DRAM into self-refresh. The warm reset is applied when the controller acknowledges, or when a fixed cycle budget runs out, whichever comes first.

After any reset the mode is Standby. In Standby the oscillator and display enables are off. Run enables every clock. Halt stops only the processor clock until a wake event arrives. A sticky three-bit cause register records which source caused the last reset. Software clears it by writing ones.

Top module: `rstpm_ctrl`

## Requirements
- R1: Driving `por_n` low forces `sys_rst_n` and `ret_rst_n` low at once, without waiting for a clock edge. It also sets `mode` to Standby (00) and sets `cause` to 3'b100.
- R2: After `por_n` returns high, both reset outputs stay low through the first rising clock edge and go high after the second.
- R3: A power-fail or user request (`pfail_n` or `ureset_n` low) raises `sr_req` after the third rising edge. Throughout the warm sequence, `ret_rst_n` stays high.
- R4: During the warm sequence, `sys_rst_n` goes low, and `sr_req` goes low, after the rising edge that samples `sr_ack` high.
- R5: If `sr_ack` never arrives, `sr_req` stays high for exactly TIMEOUT_CYC cycles. `sys_rst_n` then goes low anyway.
- R6: Once both warm inputs are high again, `sys_rst_n` stays low for two edges and rises after the third. At that point `mode` is Standby.
- R7: Each reset sets one sticky bit in `cause`: bit2 for power-on, bit1 for power-fail, bit0 for user. If power-fail and user are active together, only bit1 is set. The bits survive a warm reset.
- R8: A write (`cause_wr` high) clears exactly the `cause` bits that are 1 in `cause_wdata`, one edge later. All other bits are left unchanged.
- R9: The mode encoding is Standby=00, Run=01, Halt=10. The transitions are:
  - Standby goes to Run on `run_req`.
  - Run goes to Standby on `sleep_req`. `sleep_req` has priority over `halt_req`.
  - Run goes to Halt on `halt_req`.
  - Halt goes to Run on `wake`.
  - Any other request has no effect.
  - Each transition takes effect after one edge.
- R10: The clock enables follow the mode:
  - Run: `cpu_clk_en`, `osc_en` and `disp_en` are all 1.
  - Halt: `cpu_clk_en` is 0, and `osc_en` and `disp_en` are 1.
  - Standby: all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low |
| pfail_n | input | 1 | Power-fail reset, active low |
| ureset_n | input | 1 | User reset, active low |
| sr_ack | input | 1 | Memory controller confirms self-refresh |
| run_req | input | 1 | Leave Standby for Run |
| halt_req | input | 1 | Enter Halt from Run |
| wake | input | 1 | Wake event, leave Halt for Run |
| sleep_req | input | 1 | Enter Standby from Run |
| cause_wr | input | 1 | Write strobe for cause clearing |
| cause_wdata | input | 3 | Ones mark cause bits to clear |
| sys_rst_n | output | 1 | General-domain reset, active low |
| ret_rst_n | output | 1 | Retained-domain reset, active low |
| sr_req | output | 1 | Self-refresh request to memory controller |
| mode | output | 2 | Current power mode |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| disp_en | output | 1 | Display enable |
| cause | output | 3 | Sticky reset cause bits |

## Verification
The hardest situation to reach is the timeout path. It needs a warm request held low for the entire handshake window while `sr_ack` is held off. Its edge count also has to be told apart from the acknowledged path's. The bench builds the design with a short window and counts edges from the request. It checks that `sr_req` is still high one edge before the limit and that the system reset lands exactly on the limit. Simultaneous power-fail and user requests are driven in the same cycle, after the cause register has been cleared, so that the priority rule is observable.

// File: rtl/rstpm_ctrl.sv
module rstpm_ctrl #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pfail_n,
  input  logic       ureset_n,
  input  logic       sr_ack,
  input  logic       run_req,
  input  logic       halt_req,
  input  logic       wake,
  input  logic       sleep_req,
  input  logic       cause_wr,
  input  logic [2:0] cause_wdata,
  output logic       sys_rst_n,
  output logic       ret_rst_n,
  output logic       sr_req,
  output logic [1:0] mode,
  output logic       cpu_clk_en,
  output logic       osc_en,
  output logic       disp_en,
  output logic [2:0] cause
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [1:0] M_STBY = 2'b00, M_RUN = 2'b01, M_HALT = 2'b10;
  localparam logic [1:0] P_NORM = 2'b00, P_HSHK = 2'b01, P_WARM = 2'b10;

  logic [1:0]    por_q, pf_q, ur_q, phase;
  logic [CW-1:0] cnt;
  logic          por_ok, pf_on, ur_on, warm, hs_done;

  assign por_ok  = por_q[1];
  assign pf_on   = ~pf_q[1];
  assign ur_on   = ~ur_q[1];
  assign warm    = pf_on | ur_on;
  assign hs_done = sr_ack || (cnt == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_q <= 2'b00;
      pf_q  <= 2'b11;
      ur_q  <= 2'b11;
    end else begin
      por_q <= {por_q[0], 1'b1};
      pf_q  <= {pf_q[0], pfail_n};
      ur_q  <= {ur_q[0], ureset_n};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase <= P_NORM;
      cnt   <= '0;
    end else if (por_ok) begin
      case (phase)
        P_NORM: if (warm) begin
          phase <= P_HSHK;
          cnt   <= '0;
        end
        P_HSHK: if (hs_done) phase <= P_WARM;
                else         cnt   <= cnt + 1'b1;
        default: if (!warm) phase <= P_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause <= 3'b100;
    end else begin
      cause <= cause & ~(cause_wr ? cause_wdata : 3'b000);
      if (por_ok && phase == P_NORM && warm)
        cause[pf_on ? 1 : 0] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode <= M_STBY;
    end else if (!por_ok || phase != P_NORM) begin
      mode <= M_STBY;
    end else begin
      case (mode)
        M_STBY:  if (run_req) mode <= M_RUN;
        M_RUN:   if (sleep_req) mode <= M_STBY;
                 else if (halt_req) mode <= M_HALT;
        M_HALT:  if (wake) mode <= M_RUN;
        default: mode <= M_STBY;
      endcase
    end
  end

  assign ret_rst_n  = por_ok;
  assign sys_rst_n  = por_ok && (phase != P_WARM);
  assign sr_req     = (phase == P_HSHK);
  assign cpu_clk_en = (mode == M_RUN);
  assign osc_en     = (mode == M_RUN) || (mode == M_HALT);
  assign disp_en    = osc_en;
endmodule

// File: rtl/rstpm_ctrl_chk.sv
module rstpm_ctrl_chk #(
  parameter int TIMEOUT_CYC = 16
) (
  input logic clk,
  input logic por_n,
  input logic sys_rst_n,
  input logic ret_rst_n,
  input logic sr_req,
  input logic cpu_clk_en,
  input logic osc_en,
  input logic disp_en
);
  logic [31:0] hs_len;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) hs_len <= '0;
    else        hs_len <= sr_req ? hs_len + 1 : '0;

  AST_RET_IMPLIES_SYS: assert property (@(posedge clk) disable iff (!por_n)
    !ret_rst_n |-> !sys_rst_n);                                         // R1
  AST_NO_REQ_IN_RET_RST: assert property (@(posedge clk) disable iff (!por_n)
    sr_req |-> ret_rst_n);                                              // R3
  AST_WARM_AFTER_REQ: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(sys_rst_n) && ret_rst_n) |-> $past(sr_req));                 // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!por_n)
    sr_req |-> (hs_len < 32'(TIMEOUT_CYC)));                            // R5
  AST_WAKE_IN_STANDBY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> !osc_en);                                      // R6
  AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (!por_n)
    cpu_clk_en |-> (osc_en && disp_en));                                // R10
  AST_RESET_GATES_CPU: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> !cpu_clk_en);                                        // R10
endmodule

bind rstpm_ctrl rstpm_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .ret_rst_n(ret_rst_n),
  .sr_req(sr_req), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .disp_en(disp_en)
);

// File: tb/sim_rstpm_ctrl.sv
`timescale 1ns/1ps
module sim_rstpm_ctrl;
  localparam int T = 8;
  logic clk = 0, por_n = 0, pfail_n = 1, ureset_n = 1, sr_ack = 0;
  logic run_req = 0, halt_req = 0, wake = 0, sleep_req = 0, cause_wr = 0;
  logic [2:0] cause_wdata = 0;
  logic sys_rst_n, ret_rst_n, sr_req, cpu_clk_en, osc_en, disp_en;
  logic [1:0] mode;
  logic [2:0] cause;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  rstpm_ctrl #(.TIMEOUT_CYC(T)) u0 (.*);

  // {run_req, halt_req, wake, sleep_req, mode[1:0], cpu, osc, disp}
  localparam logic [8:0] VEC [11] = '{
    9'b0000_00_000, 9'b0100_00_000, 9'b1000_01_111, 9'b0010_01_111,
    9'b0100_10_011, 9'b1000_10_011, 9'b0010_01_111, 9'b0101_00_000,
    9'b0001_00_000, 9'b1000_01_111, 9'b0001_00_000 };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cause(input logic [2:0] m);
    cause_wr = 1; cause_wdata = m; step(1); cause_wr = 0; cause_wdata = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(2);
    chk("R1 reset sys", sys_rst_n, 0);
    chk("R1 reset ret", ret_rst_n, 0);
    chk("R1 reset cause", cause, 3'b100);
    chk("R1 reset mode", mode, 0);
    por_n = 1;
    step(1);
    chk("R2 still low after 1 edge", {sys_rst_n, ret_rst_n}, 0);
    step(1);
    chk("R2 released after 2 edges", {sys_rst_n, ret_rst_n}, 2'b11);

    for (int i = 0; i < 11; i++) begin
      {run_req, halt_req, wake, sleep_req} = VEC[i][8:5];
      step(1);
      chk($sformatf("R9 mode vec %0d", i), mode, VEC[i][4:3]);
      chk($sformatf("R10 enables vec %0d", i), {cpu_clk_en, osc_en, disp_en}, VEC[i][2:0]);
    end
    {run_req, halt_req, wake, sleep_req} = 0;

    clr_cause(3'b001);
    chk("R8 masked clear keeps bit2", cause, 3'b100);
    clr_cause(3'b100);
    chk("R8 clear bit2", cause, 3'b000);

    run_req = 1; step(1); run_req = 0;
    pfail_n = 0;
    step(2);
    chk("R3 no req after 2 edges", sr_req, 0);
    step(1);
    chk("R3 req after 3 edges", sr_req, 1);
    chk("R3 sys held during handshake", sys_rst_n, 1);
    chk("R7 pfail cause", cause, 3'b010);
    step(2);
    sr_ack = 1; step(1); sr_ack = 0;
    chk("R4 sys low after ack", sys_rst_n, 0);
    chk("R4 req dropped", sr_req, 0);
    chk("R3 ret kept", ret_rst_n, 1);
    pfail_n = 1;
    step(2);
    chk("R6 still in reset", sys_rst_n, 0);
    step(1);
    chk("R6 released", sys_rst_n, 1);
    chk("R6 standby after warm", mode, 0);
    chk("R7 cause survives warm", cause, 3'b010);

    clr_cause(3'b111);
    ureset_n = 0;
    step(3);
    chk("R5 req up", sr_req, 1);
    chk("R7 user cause", cause, 3'b001);
    step(T - 1);
    chk("R5 req before limit", {sr_req, sys_rst_n}, 2'b11);
    step(1);
    chk("R5 sys low at limit", {sr_req, sys_rst_n}, 2'b00);
    chk("R3 ret kept on timeout", ret_rst_n, 1);
    ureset_n = 1;
    step(3);
    chk("R6 released after user", sys_rst_n, 1);

    clr_cause(3'b111);
    pfail_n = 0; ureset_n = 0;
    step(3);
    chk("R7 priority pfail over user", cause, 3'b010);
    sr_ack = 1; step(1); sr_ack = 0;
    pfail_n = 1; ureset_n = 1;
    step(3);
    chk("R6 released after both", sys_rst_n, 1);

    run_req = 1; step(1); run_req = 0;
    chk("R9 run before por", mode, 2'b01);
    #5 por_n = 0;
    #1;
    chk("R1 async sys", sys_rst_n, 0);
    chk("R1 async ret", ret_rst_n, 0);
    chk("R1 cause after por", cause, 3'b100);
    chk("R1 mode after por", mode, 0);
    step(1);
    por_n = 1;
    step(2);
    chk("R2 released again", {sys_rst_n, ret_rst_n}, 2'b11);

    finish_run();
  end
endmodule